// File: doc/BRIEF.md
# Indirect register access bridge

This block lets a host with a narrow register port reach a wide internal register file through three host-visible registers. There is an 8-bit control/status register, a 16-bit address pointer and a 32-bit data window. The host picks read or write mode, a byte mask and an address-stepping mode in the control register. It then uses the pointer and the window to move whole 32-bit words to and from the internal file.

In read mode, writing the address pointer starts an internal fetch. A busy flag holds for a fixed number of cycles, and then the window shows all four bytes of the addressed word. In write mode, the host fills the window lane by lane. Only the lanes enabled in the control mask are accepted. The write to the highest enabled lane commits the word, and only the masked lanes of the target register are updated. After every completed transfer, the pointer can step by +1, -1 or +8. While busy is set, every host write is dropped.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset the control register reads 0x00, the address pointer reads 0x0000, the data window reads 0x00000000, and every internal register holds zero.
- R2: Control register layout: bit 0 selects the direction (1 = write, 0 = read), bit 1 is the busy flag, bits 3:2 are the stepping mode and bits 7:4 are the lane mask. A host write reaches it only when byte strobe 0 is set, and the busy bit cannot be written.
- R3: The address pointer is written by lane: strobe 0 loads bits 7:0, strobe 1 loads bits 15:8, and both strobes together load the full halfword. In write mode, a pointer write starts no transfer.
- R4: In read mode, a pointer write starts a fetch. Busy reads 1 for exactly 2 cycles. When it clears, the window holds all four bytes of the internal register selected by the new pointer.
- R5: In write mode, a window write changes only the lanes whose byte strobe and mask bit are both set. In read mode, window writes are ignored.
- R6: In write mode, a window write that strobes the highest set mask lane commits the transfer. Busy reads 1 for 2 cycles, and then only the masked lanes of the addressed register take the window bytes, while its other lanes keep their old value.
- R7: Stepping mode 0 holds the pointer, 1 adds 1, 2 subtracts 1 and 3 adds 8, all modulo 2^16. The step is applied when each transfer completes. The internal register is chosen by the low log2(depth) pointer bits.
- R8: While busy is 1, host writes to the control register, pointer and window are all ignored.
- R9: With a zero lane mask, window writes in write mode neither start a transfer nor change the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe |
| h_sel | input | 2 | Register select: 0 control, 1 address pointer, 2 data window |
| h_be | input | 4 | Byte strobes within the selected register |
| h_wdata | input | 32 | Host write data, lane n in bits 8n+7:8n |
| ctrl_o | output | 8 | Control/status register contents |
| addr_o | output | 16 | Address pointer contents |
| data_o | output | 32 | Data window contents |

## Verification
The bench builds the block with the default 64-entry register file and a 2-cycle transfer latency. With these values the 2-cycle busy window is short enough that host writes can be placed on each busy cycle, including the completion cycle. Because the file is smaller than the 16-bit pointer range, the pointer wrapping from 0xFFFC by +8 and a fetch at index 60 show that the low pointer bits alias onto the file. A decrement from zero reaches the 0xFFFF wrap.

// File: rtl/ibr_pkg.sv
`timescale 1ns/1ps
package ibr_pkg;
  localparam int unsigned ADDR_W     = 16;
  localparam int unsigned LANES      = 4;
  localparam int unsigned DATA_W     = LANES * 8;
  localparam int unsigned LANE_IDX_W = $clog2(LANES);

  typedef enum logic [1:0] {
    HS_CTRL = 2'd0,
    HS_ADDR = 2'd1,
    HS_DATA = 2'd2,
    HS_NONE = 2'd3
  } host_sel_e;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP1  = 2'd1,
    STEP_DN1  = 2'd2,
    STEP_UP8  = 2'd3
  } step_e;

  // Pointer after a completed transfer, modulo 2^ADDR_W
  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input step_e m);
    case (m)
      STEP_UP1: step_addr = a + ADDR_W'(1);
      STEP_DN1: step_addr = a - ADDR_W'(1);
      STEP_UP8: step_addr = a + ADDR_W'(8);
      default:  step_addr = a;
    endcase
  endfunction

  // Index of the most significant set lane bit (0 if none)
  function automatic logic [LANE_IDX_W-1:0] top_lane(input logic [LANES-1:0] m);
    top_lane = '0;
    for (int i = 0; i < LANES; i++)
      if (m[i]) top_lane = LANE_IDX_W'(i);
  endfunction

  // Take lanes of nw where en is set, keep old elsewhere
  function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old,
                                                   input logic [DATA_W-1:0] nw,
                                                   input logic [LANES-1:0]  en);
    lane_merge = old;
    for (int i = 0; i < LANES; i++)
      if (en[i]) lane_merge[i*8 +: 8] = nw[i*8 +: 8];
  endfunction
endpackage

// File: rtl/ibr_timer.sv
`timescale 1ns/1ps
module ibr_timer #(
  parameter int unsigned LATENCY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = $clog2(LATENCY + 1);

  logic [CW-1:0] cnt_q;

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (start) cnt_q <= CW'(LATENCY);
    else if (busy)  cnt_q <= cnt_q - CW'(1);
  end

  // The host side must never launch on top of a running transfer
  assert_start_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  assert_busy_after_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  assert_idle_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/ibr_regfile.sv
`timescale 1ns/1ps
module ibr_regfile
  import ibr_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [LANES-1:0]  wmask,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  idx;

  assign idx   = addr[IDX_W-1:0];
  assign rdata = mem[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= lane_merge(mem[idx], wdata, wmask);
    end
  end
endmodule

// File: rtl/ibr_host_regs.sv
`timescale 1ns/1ps
module ibr_host_regs
  import ibr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr,
  input  logic [1:0]        h_sel,
  input  logic [LANES-1:0]  h_be,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              start,
  output logic              rf_we,
  output logic [LANES-1:0]  rf_mask,
  output logic [DATA_W-1:0] rf_wdata,
  output logic [7:0]        ctrl_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  host_sel_e         sel;
  logic              rw_q;
  step_e             mode_q;
  logic [LANES-1:0]  mask_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] win_q;

  logic              accept, ctrl_wr, addr_wr, data_wr;
  logic              rd_launch, wr_launch;
  logic [ADDR_W-1:0] addr_new;
  logic [LANES-1:0]  lane_en;

  assign sel     = host_sel_e'(h_sel);
  assign accept  = h_wr && !busy;
  assign ctrl_wr = accept && (sel == HS_CTRL) && h_be[0];
  assign addr_wr = accept && (sel == HS_ADDR) && (h_be[1] || h_be[0]);
  assign data_wr = accept && (sel == HS_DATA) && rw_q;

  assign addr_new = {h_be[1] ? h_wdata[15:8] : addr_q[15:8],
                     h_be[0] ? h_wdata[7:0]  : addr_q[7:0]};
  assign lane_en  = h_be & mask_q;

  // Named launch events
  assign rd_launch = addr_wr && !rw_q;
  assign wr_launch = data_wr && (mask_q != '0) && h_be[top_lane(mask_q)];
  assign start     = rd_launch || wr_launch;

  assign rf_we    = done && rw_q;
  assign rf_mask  = mask_q;
  assign rf_wdata = win_q;

  assign ctrl_o = {mask_q, mode_q, busy, rw_q};
  assign addr_o = addr_q;
  assign data_o = win_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rw_q   <= 1'b0;
      mode_q <= STEP_HOLD;
      mask_q <= '0;
      addr_q <= '0;
      win_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        rw_q   <= h_wdata[0];
        mode_q <= step_e'(h_wdata[3:2]);
        mask_q <= h_wdata[7:4];
      end
      if (addr_wr) addr_q <= addr_new;
      if (data_wr) win_q  <= lane_merge(win_q, h_wdata, lane_en);
      if (done) begin
        addr_q <= step_addr(addr_q, mode_q);
        if (!rw_q) win_q <= rf_rdata;
      end
    end
  end

  assert_ctrl_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({rw_q, mode_q, mask_q}));
  assert_window_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(win_q));
  assert_read_mode_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rw_q && !done) |=> $stable(win_q));
  assert_step_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (addr_q == step_addr($past(addr_q), $past(mode_q))));
  assert_no_launch_mask0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !wr_launch);
endmodule

// File: rtl/ind_reg_bridge.sv
`timescale 1ns/1ps
module ind_reg_bridge
  import ibr_pkg::*;
#(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned LATENCY = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_wr,
  input  logic [1:0]  h_sel,
  input  logic [3:0]  h_be,
  input  logic [31:0] h_wdata,
  output logic [7:0]  ctrl_o,
  output logic [15:0] addr_o,
  output logic [31:0] data_o
);
  logic              start, busy, done, rf_we;
  logic [LANES-1:0]  rf_mask;
  logic [DATA_W-1:0] rf_wdata, rf_rdata;

  ibr_timer #(.LATENCY(LATENCY)) timer_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
  );

  ibr_host_regs host_i (
    .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_sel(h_sel), .h_be(h_be),
    .h_wdata(h_wdata), .busy(busy), .done(done), .rf_rdata(rf_rdata),
    .start(start), .rf_we(rf_we), .rf_mask(rf_mask), .rf_wdata(rf_wdata),
    .ctrl_o(ctrl_o), .addr_o(addr_o), .data_o(data_o)
  );

  ibr_regfile #(.DEPTH(DEPTH)) rf_i (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .wmask(rf_mask), .addr(addr_o),
    .wdata(rf_wdata), .rdata(rf_rdata)
  );
endmodule

// File: tb/ind_reg_bridge_tb_top.sv
`timescale 1ns/1ps
module ind_reg_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_wr = 1'b0;
  logic [1:0]  h_sel = 2'd3;
  logic [3:0]  h_be = 4'h0;
  logic [31:0] h_wdata = '0;
  logic [7:0]  ctrl_o;
  logic [15:0] addr_o;
  logic [31:0] data_o;

  int n_checks = 0;
  int n_fail   = 0;

  localparam logic [1:0] S_CTRL = 2'd0, S_ADDR = 2'd1, S_DATA = 2'd2;

  always #4 clk = ~clk;  // 125 MHz

  ind_reg_bridge #(.DEPTH(64), .LATENCY(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_sel(h_sel), .h_be(h_be),
    .h_wdata(h_wdata), .ctrl_o(ctrl_o), .addr_o(addr_o), .data_o(data_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Called at a negedge; holds the write over one rising edge
  task automatic hw(input logic [1:0] sel, input logic [3:0] be, input logic [31:0] d);
    h_wr = 1'b1; h_sel = sel; h_be = be; h_wdata = d;
    @(negedge clk);
    h_wr = 1'b0; h_sel = 2'd3; h_be = 4'h0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (ctrl_o[1] && n < 50) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    int n;
    chk("R1 ctrl", {24'd0, ctrl_o}, 32'h00);
    chk("R1 addr", {16'd0, addr_o}, 32'h0000);
    chk("R1 data", data_o, 32'h0);
    hw(S_ADDR, 4'h3, 32'd5);
    wait_idle(n);
    chk("R4 busy cycles", n, 2);
    chk("R1 reg5 zero", data_o, 32'h0);
    chk("R7 hold mode", {16'd0, addr_o}, 32'd5);
  endtask

  task automatic t_ctrl;
    hw(S_CTRL, 4'h1, 32'hF5);
    chk("R2 fields", {24'd0, ctrl_o}, 32'hF5);
    hw(S_CTRL, 4'h1, 32'h02);
    chk("R2 busy read-only", {24'd0, ctrl_o}, 32'h00);
    hw(S_CTRL, 4'h0, 32'hF5);
    chk("R2 strobe0 needed", {24'd0, ctrl_o}, 32'h00);
  endtask

  task automatic t_addr;
    hw(S_CTRL, 4'h1, 32'h01);
    hw(S_ADDR, 4'h1, 32'h0000AB34);
    chk("R3 low byte", {16'd0, addr_o}, 32'h0034);
    chk("R3 no launch", {24'd0, ctrl_o}, 32'h01);
    hw(S_ADDR, 4'h2, 32'h00001299);
    chk("R3 high byte", {16'd0, addr_o}, 32'h1234);
    hw(S_ADDR, 4'h3, 32'h0000BEEF);
    chk("R3 halfword", {16'd0, addr_o}, 32'hBEEF);
  endtask

  task automatic t_full_write;
    int n;
    hw(S_CTRL, 4'h1, 32'hF1);
    hw(S_ADDR, 4'h3, 32'd3);
    hw(S_DATA, 4'hF, 32'hDEADBEEF);
    wait_idle(n);
    chk("R6 busy cycles", n, 2);
    hw(S_CTRL, 4'h1, 32'h00);
    hw(S_ADDR, 4'h3, 32'd3);
    wait_idle(n);
    chk("R6 full word", data_o, 32'hDEADBEEF);
  endtask

  task automatic t_partial;
    int n;
    hw(S_CTRL, 4'h1, 32'hF1);
    hw(S_ADDR, 4'h3, 32'd7);
    hw(S_DATA, 4'hF, 32'hAAAAAAAA);
    wait_idle(n);
    hw(S_CTRL, 4'h1, 32'h00);
    hw(S_ADDR, 4'h3, 32'd9);
    wait_idle(n);
    chk("R4 fetch zero", data_o, 32'h0);
    hw(S_CTRL, 4'h1, 32'h31);
    hw(S_ADDR, 4'h3, 32'd7);
    hw(S_DATA, 4'h1, 32'h55555578);
    chk("R5 lane0 only", data_o, 32'h00000078);
    chk("R6 no commit below top", {24'd0, ctrl_o}, 32'h31);
    hw(S_DATA, 4'hE, 32'h99991299);
    chk("R6 commit busy", {31'd0, ctrl_o[1]}, 32'd1);
    chk("R5 masked lanes", data_o, 32'h00001278);
    wait_idle(n);
    hw(S_CTRL, 4'h1, 32'h00);
    hw(S_ADDR, 4'h3, 32'd7);
    wait_idle(n);
    chk("R6 merged word", data_o, 32'hAAAA1278);
    hw(S_DATA, 4'hF, 32'h12345678);
    chk("R5 read-mode ignore", data_o, 32'hAAAA1278);
    chk("R5 read-mode no busy", {24'd0, ctrl_o}, 32'h00);
  endtask

  task automatic t_mask0;
    hw(S_CTRL, 4'h1, 32'h01);
    hw(S_DATA, 4'hF, 32'h0BADF00D);
    chk("R9 no busy", {24'd0, ctrl_o}, 32'h01);
    chk("R9 window kept", data_o, 32'hAAAA1278);
  endtask

  task automatic t_step;
    int n;
    hw(S_CTRL, 4'h1, 32'hF5);
    hw(S_ADDR, 4'h3, 32'd10);
    for (int i = 0; i < 3; i++) begin
      hw(S_DATA, 4'hF, 32'h100 + i);
      wait_idle(n);
    end
    chk("R7 inc1", {16'd0, addr_o}, 32'd13);
    hw(S_CTRL, 4'h1, 32'h08);
    hw(S_ADDR, 4'h3, 32'd12);
    wait_idle(n);
    chk("R7 read word12", data_o, 32'h102);
    chk("R7 dec1", {16'd0, addr_o}, 32'd11);
    hw(S_ADDR, 4'h3, 32'd11);
    wait_idle(n);
    chk("R7 read word11", data_o, 32'h101);
    hw(S_CTRL, 4'h1, 32'hFD);
    hw(S_ADDR, 4'h3, 32'hFFFC);
    hw(S_DATA, 4'hF, 32'hC0FFEE00);
    wait_idle(n);
    chk("R7 inc8 wrap", {16'd0, addr_o}, 32'h0004);
    hw(S_CTRL, 4'h1, 32'h08);
    hw(S_ADDR, 4'h3, 32'd60);
    wait_idle(n);
    chk("R7 index alias", data_o, 32'hC0FFEE00);
    hw(S_ADDR, 4'h3, 32'd0);
    wait_idle(n);
    chk("R7 dec wrap", {16'd0, addr_o}, 32'hFFFF);
    chk("R7 word0", data_o, 32'h0);
  endtask

  task automatic t_busy_ignore;
    int n;
    hw(S_CTRL, 4'h1, 32'h04);
    hw(S_ADDR, 4'h3, 32'd12);
    hw(S_CTRL, 4'h1, 32'hFF);
    hw(S_ADDR, 4'h3, 32'h0777);
    wait_idle(n);
    chk("R8 ctrl kept", {24'd0, ctrl_o}, 32'h04);
    chk("R8 addr stepped only", {16'd0, addr_o}, 32'd13);
    chk("R8 data fetched", data_o, 32'h102);
  endtask

  initial begin
    #(8 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_ctrl;
    t_addr;
    t_full_write;
    t_partial;
    t_mask0;
    t_step;
    t_busy_ignore;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule